// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block is a register-mapped general-purpose I/O controller for 128 pin positions arranged as four banks of 32. Software reaches it through a plain 32-bit register bus with separate read and write strobes and a one-cycle registered read path. Each bank holds an output value register, a per-pin direction register and a per-pin output-enable register. A pin is driven only when it is set to output and also enabled, so an output pin can be held in tristate without losing its direction setting.

Output bits can be changed atomically through two half-word masked-write ports per bank. The upper half of the written word is an active-low per-bit mask and the lower half is the new value, so one write sets or clears any subset of sixteen outputs without a read-modify-write sequence. Inputs pass through a two-stage synchronizer and feed a per-bank interrupt unit with programmable edge or level trigger, polarity and a both-edges option, sticky status bits cleared by writing ones, and a mask controlled through separate set and clear registers. One interrupt line summarises every bank.

Bank 1 only populates its lower 22 positions; the other banks are fully populated. Unpopulated bits never drive, never raise status and read as zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin output and pin enable is 0, `irq` is 0, the direction, enable, value, polarity, both-edges and status registers read 0, and the mask and trigger-type registers read as all populated bits set (0xFFFFFFFF for banks 0, 2, 3 and 0x003FFFFF for bank 1).
- R2: The value register of bank b sits at byte address 0x40+4*b, reads back what was written and drives `pin_out[32*b+i]` from bit i; bits of unpopulated positions (bank 1 bits 31:22) read 0 and stay 0 on `pin_out`.
- R3: A write to address 8*b changes bits 15:0 and a write to 8*b+4 changes bits 31:16 of the bank b value register; within the half, bit k takes `wdata[k]` when `wdata[16+k]` is 0 and keeps its value when `wdata[16+k]` is 1.
- R4: Address 0x60+4*b returns the bank b pin levels as seen after a two-flop synchronizer (masked to populated bits); writes there change nothing.
- R5: Direction (1 = output) sits at 0x204+0x40*b and output enable at 0x208+0x40*b; `pin_oe` of a pin is 1 only when both its bits are 1.
- R6: Writing ones to 0x210+0x40*b clears those mask bits, writing ones to 0x214+0x40*b sets them, zero bits change nothing, the mask reads at 0x20C+0x40*b (1 = masked) and the two command addresses read 0.
- R7: Status at 0x218+0x40*b latches each qualifying event whether or not the pin is masked, holds it until a one is written to that bit, ignores written zeros, and an event in the same cycle as a clear leaves the bit set.
- R8: Trigger type at 0x21C+0x40*b (1 = edge, 0 = level), polarity at 0x220+0x40*b (1 = rising or high, 0 = falling or low) and both-edges at 0x224+0x40*b (with type 1, either transition triggers); a level trigger re-sets status each cycle while the level holds.
- R9: `irq` is a register that is 1 exactly one cycle after some bank has a status bit set with its mask bit clear.
- R10: `bus_rdata` is registered: it shows the addressed register one cycle after `bus_rd`, and reads 0 when no read was issued, for unmapped addresses and for the masked-write ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 128 | Pin levels from the pads |
| pin_out | output | 128 | Output value per pin |
| pin_oe | output | 128 | Drive enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the controller with its default parameters: four banks with bank 1 populated only up to bit 21, which puts the partially populated bank, and therefore the masking of readback, drive and status by the populated set, within reach of ordinary register accesses. Directed sequences cover both masked-write halves with mixed masks, a driven-versus-tristated output pattern, edge, both-edges and level triggers with clears during a held level, and the mask command registers, while a behavioural model predicts every pin, the interrupt line and every read value on each clock.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  // Register width of the bus and of one bank
  localparam int REG_W = 32;

  // Offsets inside the per-bank control window
  localparam logic [5:0] CTL_DIR  = 6'h04;
  localparam logic [5:0] CTL_OE   = 6'h08;
  localparam logic [5:0] CTL_MASK = 6'h0C;
  localparam logic [5:0] CTL_IEN  = 6'h10;
  localparam logic [5:0] CTL_IDIS = 6'h14;
  localparam logic [5:0] CTL_STAT = 6'h18;
  localparam logic [5:0] CTL_TYPE = 6'h1C;
  localparam logic [5:0] CTL_POL  = 6'h20;
  localparam logic [5:0] CTL_ANY  = 6'h24;

  // Qualifying interrupt events for a whole bank
  function automatic logic [REG_W-1:0] trig_event(
      input logic [REG_W-1:0] cur,
      input logic [REG_W-1:0] prv,
      input logic [REG_W-1:0] typ,
      input logic [REG_W-1:0] pol,
      input logic [REG_W-1:0] anye);
    logic [REG_W-1:0] rise, fall, on_edge, on_level;
    rise     = cur & ~prv;
    fall     = ~cur & prv;
    on_edge  = (anye & (rise | fall)) | (~anye & pol & rise) | (~anye & ~pol & fall);
    on_level = (pol & cur) | (~pol & ~cur);
    return (typ & on_edge) | (~typ & on_level);
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int           W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wdata,
  input  logic         we_full,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic         we_dir,
  input  logic         we_oe,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] oe_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);

  localparam int HALF = W / 2;

  logic [W-1:0] val_q, val_n;
  logic [W-1:0] dir_n, oe_n;
  logic [W-1:0] drive_q;
  logic [HALF-1:0] keep;

  assign keep = wdata[W-1:HALF];

  always_comb begin
    val_n = val_q;
    if (we_full) val_n = wdata;
    if (we_lo)
      val_n[HALF-1:0] = (val_q[HALF-1:0] & keep) | (wdata[HALF-1:0] & ~keep);
    if (we_hi)
      val_n[W-1:HALF] = (val_q[W-1:HALF] & keep) | (wdata[HALF-1:0] & ~keep);
    val_n = val_n & VALID;
    dir_n = we_dir ? (wdata & VALID) : dir_q;
    oe_n  = we_oe  ? (wdata & VALID) : oe_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= '0;
      dir_q   <= '0;
      oe_q    <= '0;
      drive_q <= '0;
    end else begin
      val_q   <= val_n;
      dir_q   <= dir_n;
      oe_q    <= oe_n;
      drive_q <= dir_n & oe_n;
    end
  end

  assign pin_out = val_q;
  assign pin_oe  = drive_q;

  // R3: bits whose mask bit was 1 keep their value
  assert_lo_keep_R3: assert property (@(posedge clk) disable iff (rst)
    we_lo |=> (((pin_out[HALF-1:0] ^ $past(pin_out[HALF-1:0])) & $past(wdata[W-1:HALF])) == '0));

  assert_hi_keep_R3: assert property (@(posedge clk) disable iff (rst)
    we_hi |=> (((pin_out[W-1:HALF] ^ $past(pin_out[W-1:HALF])) & $past(wdata[W-1:HALF])) == '0));

  // R5: a pin set to input never drives
  assert_input_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
    we_dir |=> ((pin_oe & ~$past(wdata)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_ctrl_pkg::*;
#(
  parameter logic [REG_W-1:0] VALID = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] sync_in,
  input  logic [REG_W-1:0] wdata,
  input  logic             we_ien,
  input  logic             we_idis,
  input  logic             we_stat,
  input  logic             we_type,
  input  logic             we_pol,
  input  logic             we_any,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] type_q,
  output logic [REG_W-1:0] pol_q,
  output logic [REG_W-1:0] any_q,
  output logic             pending
);

  logic [REG_W-1:0] prev_q;
  logic [REG_W-1:0] evt;
  logic [REG_W-1:0] clr;
  logic [REG_W-1:0] mask_n;

  assign evt = trig_event(sync_in, prev_q, type_q, pol_q, any_q) & VALID;
  assign clr = we_stat ? wdata : '0;

  always_comb begin
    mask_n = mask_q;
    if (we_ien)  mask_n = mask_n & ~wdata;
    if (we_idis) mask_n = mask_n | (wdata & VALID);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      mask_q <= VALID;
      type_q <= VALID;
      stat_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
    end else begin
      prev_q <= sync_in;
      mask_q <= mask_n;
      stat_q <= (stat_q & ~clr) | evt;
      if (we_type) type_q <= wdata & VALID;
      if (we_pol)  pol_q  <= wdata & VALID;
      if (we_any)  any_q  <= wdata & VALID;
    end
  end

  assign pending = |(stat_q & ~mask_q);

  // R7: without a status write no pending bit disappears
  assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !we_stat |=> (($past(stat_q) & ~stat_q) == '0));

  // R6: disable command masks every populated bit written as one
  assert_idis_sets_R6: assert property (@(posedge clk) disable iff (rst)
    we_idis |=> ((mask_q & $past(wdata & VALID)) == $past(wdata & VALID)));

  // R6: enable command unmasks every bit written as one
  assert_ien_clears_R6: assert property (@(posedge clk) disable iff (rst)
    we_ien |=> ((mask_q & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 10,
  parameter logic [NUM_BANKS*REG_W-1:0] PIN_VALID =
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h003F_FFFF, 32'hFFFF_FFFF}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [REG_W-1:0]           bus_wdata,
  output logic [REG_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*REG_W-1:0] pin_in,
  output logic [NUM_BANKS*REG_W-1:0] pin_out,
  output logic [NUM_BANKS*REG_W-1:0] pin_oe,
  output logic                       irq
);

  logic [REG_W-1:0]     bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend;
  logic [REG_W-1:0]     rd_all;
  logic [REG_W-1:0]     rdata_q;
  logic                 irq_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [REG_W-1:0]  VB       = PIN_VALID[b*REG_W +: REG_W];
    localparam logic [ADDR_W-1:0] LO_A     = ADDR_W'(8 * b);
    localparam logic [ADDR_W-1:0] HI_A     = ADDR_W'(8 * b + 4);
    localparam logic [ADDR_W-1:0] VAL_A    = ADDR_W'(64 + 4 * b);
    localparam logic [ADDR_W-1:0] IN_A     = ADDR_W'(96 + 4 * b);
    localparam logic [ADDR_W-1:0] CTL_BASE = ADDR_W'(512 + 64 * b);

    logic             ctl_hit;
    logic [5:0]       off;
    logic [REG_W-1:0] sync_v, dir_v, oe_v, mask_v, stat_v, type_v, pol_v, any_v;
    logic [REG_W-1:0] rd_v;

    assign ctl_hit = (bus_addr[ADDR_W-1:6] == CTL_BASE[ADDR_W-1:6]);
    assign off     = bus_addr[5:0];

    gpio_sync2 #(.W(REG_W)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (pin_in[b*REG_W +: REG_W]),
      .sync_out (sync_v)
    );

    gpio_pin_bank #(.W(REG_W), .VALID(VB)) u_pins (
      .clk     (clk),
      .rst     (rst),
      .wdata   (bus_wdata),
      .we_full (bus_wr && bus_addr == VAL_A),
      .we_lo   (bus_wr && bus_addr == LO_A),
      .we_hi   (bus_wr && bus_addr == HI_A),
      .we_dir  (bus_wr && ctl_hit && off == CTL_DIR),
      .we_oe   (bus_wr && ctl_hit && off == CTL_OE),
      .dir_q   (dir_v),
      .oe_q    (oe_v),
      .pin_out (pin_out[b*REG_W +: REG_W]),
      .pin_oe  (pin_oe[b*REG_W +: REG_W])
    );

    gpio_irq_bank #(.VALID(VB)) u_irq (
      .clk     (clk),
      .rst     (rst),
      .sync_in (sync_v),
      .wdata   (bus_wdata),
      .we_ien  (bus_wr && ctl_hit && off == CTL_IEN),
      .we_idis (bus_wr && ctl_hit && off == CTL_IDIS),
      .we_stat (bus_wr && ctl_hit && off == CTL_STAT),
      .we_type (bus_wr && ctl_hit && off == CTL_TYPE),
      .we_pol  (bus_wr && ctl_hit && off == CTL_POL),
      .we_any  (bus_wr && ctl_hit && off == CTL_ANY),
      .mask_q  (mask_v),
      .stat_q  (stat_v),
      .type_q  (type_v),
      .pol_q   (pol_v),
      .any_q   (any_v),
      .pending (bank_pend[b])
    );

    always_comb begin
      rd_v = '0;
      if (bus_addr == VAL_A) begin
        rd_v = pin_out[b*REG_W +: REG_W];
      end else if (bus_addr == IN_A) begin
        rd_v = sync_v & VB;
      end else if (ctl_hit) begin
        case (off)
          CTL_DIR:  rd_v = dir_v;
          CTL_OE:   rd_v = oe_v;
          CTL_MASK: rd_v = mask_v;
          CTL_STAT: rd_v = stat_v;
          CTL_TYPE: rd_v = type_v;
          CTL_POL:  rd_v = pol_v;
          CTL_ANY:  rd_v = any_v;
          default:  rd_v = '0;
        endcase
      end
    end

    assign bank_rd[b] = rd_v;
  end

  always_comb begin
    rd_all = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_all = rd_all | bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= bus_rd ? rd_all : '0;
      irq_q   <= |bank_pend;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // R10: idle read port returns zero
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R9: interrupt line follows unmasked status one cycle later
  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (|bank_pend) |=> irq);

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !(|bank_pend) |=> !irq);

endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;

  localparam int NB = 4;
  localparam int NP = NB * 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [9:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   pin_in = '0;
  logic [NP-1:0]   pin_out;
  logic [NP-1:0]   pin_oe;
  logic            irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural model ----------------
  logic [31:0] vb [NB] = '{32'hFFFF_FFFF, 32'h003F_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  logic [31:0] m_val [NB], m_dir [NB], m_oe [NB], m_mask [NB];
  logic [31:0] m_stat [NB], m_typ [NB], m_pol [NB], m_any [NB];
  logic [NP-1:0] hist [$];
  logic [31:0] m_rdata;
  logic        m_irq;

  function automatic logic [31:0] ev_f(logic [31:0] c, logic [31:0] p, logic [31:0] t,
                                        logic [31:0] po, logic [31:0] an);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (t[i]) r[i] = an[i] ? (c[i] != p[i]) : (po[i] ? (c[i] && !p[i]) : (!c[i] && p[i]));
      else      r[i] = po[i] ? c[i] : !c[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r = '0;
    if (a >= 64 && a < 64 + 4*NB && a % 4 == 0) r = m_val[(a-64)/4];
    else if (a >= 96 && a < 96 + 4*NB && a % 4 == 0) r = hist[1][((a-96)/4)*32 +: 32] & vb[(a-96)/4];
    else if (a >= 512 && a < 512 + 64*NB) begin
      int b = (a - 512) / 64;
      case ((a - 512) % 64)
        4:  r = m_dir[b];
        8:  r = m_oe[b];
        12: r = m_mask[b];
        24: r = m_stat[b];
        28: r = m_typ[b];
        32: r = m_pol[b];
        36: r = m_any[b];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin : mdl
    logic        irq_n;
    logic [31:0] ev, clr, d;
    int a, b, o;
    if (rst) begin
      for (int k = 0; k < NB; k++) begin
        m_val[k] = 0; m_dir[k] = 0; m_oe[k] = 0; m_stat[k] = 0;
        m_pol[k] = 0; m_any[k] = 0; m_mask[k] = vb[k]; m_typ[k] = vb[k];
      end
      hist = {};
      for (int k = 0; k < 3; k++) hist.push_back('0);
      m_rdata = 0; m_irq = 0;
    end else begin
      irq_n = 1'b0;
      for (int k = 0; k < NB; k++) if ((m_stat[k] & ~m_mask[k]) != 0) irq_n = 1'b1;
      a = int'(bus_addr);
      d = bus_wdata;
      m_rdata = bus_rd ? m_read(a) : 32'h0;
      for (int k = 0; k < NB; k++) begin
        ev  = ev_f(hist[1][k*32 +: 32], hist[2][k*32 +: 32], m_typ[k], m_pol[k], m_any[k]) & vb[k];
        clr = (bus_wr && a == 512 + 64*k + 24) ? d : 32'h0;
        m_stat[k] = (m_stat[k] & ~clr) | ev;
      end
      if (bus_wr) begin
        if (a < 8*NB) begin
          b = a / 8;
          for (int i = 0; i < 16; i++) begin
            if (!d[16+i]) begin
              if (a % 8 == 0) m_val[b][i] = d[i];
              else if (a % 8 == 4) m_val[b][16+i] = d[i];
            end
          end
          m_val[b] = m_val[b] & vb[b];
        end else if (a >= 64 && a < 64 + 4*NB && a % 4 == 0) begin
          m_val[(a-64)/4] = d & vb[(a-64)/4];
        end else if (a >= 512 && a < 512 + 64*NB) begin
          b = (a - 512) / 64;
          o = (a - 512) % 64;
          case (o)
            4:  m_dir[b]  = d & vb[b];
            8:  m_oe[b]   = d & vb[b];
            16: m_mask[b] = m_mask[b] & ~d;
            20: m_mask[b] = m_mask[b] | (d & vb[b]);
            28: m_typ[b]  = d & vb[b];
            32: m_pol[b]  = d & vb[b];
            36: m_any[b]  = d & vb[b];
            default: ;
          endcase
        end
      end
      m_irq = irq_n;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NP-1:0] eo, ee;
      for (int k = 0; k < NB; k++) begin
        eo[k*32 +: 32] = m_val[k];
        ee[k*32 +: 32] = m_dir[k] & m_oe[k];
      end
      chk("R2 model pin_out", pin_out, eo);
      chk("R5 model pin_oe", pin_oe, ee);
      chk("R9 model irq", 128'(irq), 128'(m_irq));
      chk("R10 model rdata", 128'(bus_rdata), 128'(m_rdata));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = 10'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, 128'(v), 128'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 pin_out reset", pin_out, '0);
    chk("R1 pin_oe reset", pin_oe, '0);
    chk("R1 irq reset", 128'(irq), 128'(0));
    rd_chk("R1 mask bank0", 'h20C, 32'hFFFF_FFFF);
    rd_chk("R1 mask bank1", 'h24C, 32'h003F_FFFF);
    rd_chk("R1 type bank1", 'h25C, 32'h003F_FFFF);
    rd_chk("R1 status bank3", 'h2D8, 32'h0);
    rd_chk("R1 dir bank2", 'h284, 32'h0);

    // R2 full value register
    wr('h40, 32'hA5A5_0F0F);
    rd_chk("R2 readback bank0", 'h40, 32'hA5A5_0F0F);
    chk("R2 pins bank0", 128'(pin_out[31:0]), 128'(32'hA5A5_0F0F));
    wr('h44, 32'hFFFF_FFFF);
    rd_chk("R2 unpopulated bank1", 'h44, 32'h003F_FFFF);
    chk("R2 pins bank1", 128'(pin_out[63:32]), 128'(32'h003F_FFFF));

    // R3 masked half writes on bank 2
    wr('h10, 32'hFF00_00FF);
    rd_chk("R3 low half partial", 'h48, 32'h0000_00FF);
    wr('h10, 32'h00FF_AAAA);
    rd_chk("R3 low half other part", 'h48, 32'h0000_AAFF);
    wr('h14, 32'hFFFE_0001);
    rd_chk("R3 high half bit16", 'h48, 32'h0001_AAFF);
    rd_chk("R10 masked port reads 0", 'h10, 32'h0);

    // R5 direction and enable, bank 3
    wr('h2C4, 32'h0000_FFFF);
    wr('h2C8, 32'h00FF_00FF);
    idle(1);
    chk("R5 tristated outputs", 128'(pin_oe[127:96]), 128'(32'h0000_00FF));
    rd_chk("R5 oe readback", 'h2C8, 32'h00FF_00FF);

    // R4 synchronized input sampling
    pin_in[31:0]  = 32'h1234_5678;
    pin_in[63:32] = 32'hFFFF_FFFF;
    idle(4);
    rd_chk("R4 input bank0", 'h60, 32'h1234_5678);
    rd_chk("R4 input bank1 populated", 'h64, 32'h003F_FFFF);
    wr('h60, 32'h0);
    rd_chk("R4 write ignored", 'h60, 32'h1234_5678);

    // R7/R6/R9 rising edge on bank0 bit 0
    wr('h218, 32'hFFFF_FFFF);
    wr('h220, 32'h0000_0001);
    rd_chk("R7 status cleared", 'h218, 32'h0);
    pin_in[0] = 1'b1;
    idle(4);
    rd_chk("R7 latched while masked", 'h218, 32'h0000_0001);
    chk("R9 masked no irq", 128'(irq), 128'(0));
    wr('h210, 32'h0000_0001);
    rd_chk("R6 mask after enable", 'h20C, 32'hFFFF_FFFE);
    rd_chk("R6 enable reads 0", 'h210, 32'h0);
    chk("R9 irq asserted", 128'(irq), 128'(1));
    wr('h210, 32'h0);
    rd_chk("R6 zero enable no effect", 'h20C, 32'hFFFF_FFFE);
    wr('h218, 32'h0);
    rd_chk("R7 zero clear no effect", 'h218, 32'h0000_0001);
    wr('h218, 32'h0000_0001);
    rd_chk("R7 cleared by one", 'h218, 32'h0);
    idle(1);
    chk("R9 irq dropped", 128'(irq), 128'(0));
    wr('h214, 32'h0000_0001);
    rd_chk("R6 disable masks", 'h20C, 32'hFFFF_FFFF);

    // R8 both edges on bank3 bit 5
    wr('h2E4, 32'h0000_0020);
    wr('h2D8, 32'hFFFF_FFFF);
    pin_in[101] = 1'b1;
    idle(4);
    rd_chk("R8 both-edge rise", 'h2D8, 32'h0000_0020);
    wr('h2D8, 32'hFFFF_FFFF);
    pin_in[101] = 1'b0;
    idle(4);
    rd_chk("R8 both-edge fall", 'h2D8, 32'h0000_0020);

    // R8 high level on bank2 bit 3
    wr('h2A0, 32'h0000_0008);
    wr('h29C, 32'hFFFF_FFF7);
    wr('h298, 32'hFFFF_FFFF);
    rd_chk("R8 level idle", 'h298, 32'h0);
    pin_in[67] = 1'b1;
    idle(4);
    rd_chk("R8 level latched", 'h298, 32'h0000_0008);
    wr('h298, 32'hFFFF_FFFF);
    idle(2);
    rd_chk("R8 level re-asserts", 'h298, 32'h0000_0008);
    pin_in[67] = 1'b0;
    idle(4);
    wr('h298, 32'hFFFF_FFFF);
    idle(2);
    rd_chk("R8 level released", 'h298, 32'h0);

    // R10 unmapped addresses
    rd_chk("R10 unmapped 0x300", 'h300, 32'h0);
    rd_chk("R10 unmapped 0x200", 'h200, 32'h0);
    idle(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule